// File: doc/BRIEF.md
# Field DMA Instruction Sequencer

This block is a small instruction engine that moves captured pixel data from a data FIFO into system memory. It reads 32-bit instruction words from a program memory, decodes a 4-bit opcode in the top nibble of each header word, and collects the operand words that opcode needs. It then writes FIFO words to a run of target addresses, throws FIFO words away, branches, or waits for a marker entry in the FIFO. Two programs live in the same program memory. One serves odd fields and one serves even fields, and each has its own start address.

A field-start strobe picks the program. If the FIFO stream and the program disagree, the engine does not stall or write to the wrong place. When a marker appears in the middle of a transfer, the transfer is dropped and a resync flag is raised. Write and skip instructions are then passed over until a wait instruction matches a marker. An opcode with no defined meaning stops the engine until it receives a restart strobe.

Top module: `fld_dma_seq`

## Requirements
- R1: After reset, busy, errFlag, resyncFlag, wrReq, fifoRd and imemRd are 0, and pcOut is 0.
- R2: A fieldStart pulse (outside the halted state) loads pcOut with oddStart when fieldOdd is 1 and with evenStart when it is 0. The new value is visible after the clock edge that samples the pulse.
- R3: A header word holds the opcode in bits [31:28], a start-of-line flag in bit 27, an end-of-line flag in bit 26, byte enables in [15:12] and a byte count in [11:0]. Each instruction uses this many words: 0001 uses 2, 1001 uses 5, 1011 uses 3, 0101 uses 1, 0010 uses 1, 1010 uses 2, 0111 uses 2 and 1000 uses 2. The program counter moves past all of them.
- R4: Opcodes 0001, 1001 and 1011 load the running address from the first operand word. They then issue ceil(count/4) write requests at that address and at each following +4 address, carrying FIFO words in order. wrBe bit i enables byte i. It is the header enables ANDed with a mask of the remaining bytes (low bytes only) on the last word.
- R5: Opcode 0101 writes in the same way from the running address that the previous write left behind.
- R6: Opcodes 0010 and 1010 pop ceil(count/4) FIFO data words and issue no write request.
- R7: Opcode 0111 loads the program counter with bits [IADDR_W-1:0] of its operand word.
- R8: Opcode 1000 waits. Any FIFO head entry that is not a marker whose code equals operand bits [3:0] is popped and discarded. The matching marker is popped, and execution then continues.
- R9: A write request or a pop during a transfer happens only when fifoBytes is at least 4 and the head entry is data (not a marker).
- R10: wrSol is raised with the first write of an instruction whose header start flag is set. wrEol is raised with the last write of an instruction whose end flag is set.
- R11: If a marker reaches the FIFO head before a write or skip has its byte count, the instruction is abandoned without popping the marker and resyncFlag is set. Later write and skip instructions are passed over without popping, until a wait instruction matches a marker, which clears the flag.
- R12: An undefined opcode sets errFlag and clears busy. While halted, the engine makes no requests and ignores fieldStart. A restart pulse returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fieldStart | input | 1 | Begin the program for a new field |
| fieldOdd | input | 1 | 1 selects the odd-field program |
| restart | input | 1 | Leave the halted state |
| oddStart | input | IADDR_W | Odd-field program start word index |
| evenStart | input | IADDR_W | Even-field program start word index |
| imemRd | output | 1 | Program memory read strobe |
| imemAddr | output | IADDR_W | Program memory word index |
| imemData | input | 32 | Program word, valid the cycle after imemRd |
| fifoBytes | input | FIFO_CNT_W | Bytes held in the FIFO (4 per entry) |
| fifoData | input | 32 | FIFO head data word |
| fifoHeadSync | input | 1 | FIFO head entry is a marker |
| fifoHeadCode | input | CODE_W | Marker code of the head entry |
| fifoRd | output | 1 | Pop the FIFO head |
| wrReq | output | 1 | Write request |
| wrAddr | output | ADDR_W | Write byte address |
| wrData | output | 32 | Write data |
| wrBe | output | 4 | Write byte enables |
| wrSol | output | 1 | Write is the first of a scan line |
| wrEol | output | 1 | Write is the last of a scan line |
| busy | output | 1 | A program is running |
| errFlag | output | 1 | Halted on an undefined opcode |
| resyncFlag | output | 1 | Waiting to realign with the data stream |
| pcOut | output | IADDR_W | Current program counter |

## Verification
The assertions check the following on every cycle:
- writes and pops never run ahead of the FIFO, and a write never carries a marker;
- line flags appear only on writes;
- no write is issued while the resync flag is set;
- the halted state is silent and sticky;
- a field start loads the selected start address.

Only the directed scenarios can show the rest:
- the operand lengths per opcode and the address sequence;
- the last-word byte mask;
- skip and branch behaviour;
- a wait discarding stray entries;
- the full abandon-and-realign sequence after a short line.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;

  typedef enum logic [3:0] {
    OP_PUT       = 4'b0001,
    OP_PUT3      = 4'b1001,
    OP_PUT_SPLIT = 4'b1011,
    OP_PUT_CONT  = 4'b0101,
    OP_DROP      = 4'b0010,
    OP_DROP3     = 4'b1010,
    OP_BRANCH    = 4'b0111,
    OP_WAIT      = 4'b1000
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pcStart;
    logic pcInc;
    logic pcJump;
    logic hdrLd;
    logic opLd;
    logic cntLd;
    logic addrLd;
    logic wordStep;
    logic addrStep;
  } seqCtl_t;

  // total instruction length in words, 0 for an undefined opcode
  function automatic logic [2:0] opWords(input logic [3:0] op);
    case (op)
      OP_PUT:       opWords = 3'd2;
      OP_PUT3:      opWords = 3'd5;
      OP_PUT_SPLIT: opWords = 3'd3;
      OP_PUT_CONT:  opWords = 3'd1;
      OP_DROP:      opWords = 3'd1;
      OP_DROP3:     opWords = 3'd2;
      OP_BRANCH:    opWords = 3'd2;
      OP_WAIT:      opWords = 3'd2;
      default:      opWords = 3'd0;
    endcase
  endfunction

  function automatic logic isPut(input logic [3:0] op);
    isPut = (op == OP_PUT) || (op == OP_PUT3) || (op == OP_PUT_SPLIT) || (op == OP_PUT_CONT);
  endfunction

  function automatic logic hasAddr(input logic [3:0] op);
    hasAddr = (op == OP_PUT) || (op == OP_PUT3) || (op == OP_PUT_SPLIT);
  endfunction
endpackage

// File: rtl/fds_dpath.sv
module fds_dpath
  import fds_pkg::*;
#(
  parameter int IAW  = 8,
  parameter int AW   = 32,
  parameter int CDW  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              fieldOdd,
  input  logic [IAW-1:0]    oddStart,
  input  logic [IAW-1:0]    evenStart,
  input  logic [WORD_W-1:0] imemData,
  input  logic [WORD_W-1:0] fifoData,
  input  logic [CDW-1:0]    fifoHeadCode,
  output logic [IAW-1:0]    pc,
  output logic [3:0]        hdrOp,
  output logic              remZero,
  output logic              lastWord,
  output logic              codeMatch,
  output logic              solMark,
  output logic              eolMark,
  output logic [AW-1:0]     wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic [3:0]        wrBe
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(4);

  logic [3:0]        opcReg;
  logic              solReg, eolReg;
  logic [3:0]        beReg;
  logic [CNT_W-1:0]  cntReg;
  logic [WORD_W-1:0] opReg;
  logic [CNT_W-1:0]  remBytes;
  logic [AW-1:0]     runAddr;
  logic              firstPend;
  logic [3:0]        tailMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (ctl.pcStart) begin
      pc <= fieldOdd ? oddStart : evenStart;
    end else if (ctl.pcJump) begin
      pc <= opReg[IAW-1:0];
    end else if (ctl.pcInc) begin
      pc <= pc + IAW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcReg <= '0;
      solReg <= 1'b0;
      eolReg <= 1'b0;
      beReg  <= '0;
      cntReg <= '0;
      opReg  <= '0;
    end else begin
      if (ctl.hdrLd) begin
        opcReg <= imemData[31:28];
        solReg <= imemData[27];
        eolReg <= imemData[26];
        beReg  <= imemData[15:12];
        cntReg <= imemData[11:0];
      end
      if (ctl.opLd) opReg <= imemData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remBytes  <= '0;
      firstPend <= 1'b0;
    end else if (ctl.cntLd) begin
      remBytes  <= cntReg;
      firstPend <= 1'b1;
    end else if (ctl.wordStep) begin
      remBytes  <= (remBytes > STEP) ? remBytes - STEP : '0;
      firstPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runAddr <= '0;
    end else if (ctl.addrLd) begin
      runAddr <= opReg[AW-1:0];
    end else if (ctl.addrStep) begin
      runAddr <= runAddr + AW'(4);
    end
  end

  always_comb begin
    if (remBytes >= STEP) tailMask = 4'hF;
    else tailMask = 4'((5'd1 << remBytes[1:0]) - 5'd1);
  end

  assign hdrOp     = opcReg;
  assign remZero   = (remBytes == '0);
  assign lastWord  = (remBytes <= STEP);
  assign codeMatch = (fifoHeadCode == opReg[CDW-1:0]);
  assign solMark   = solReg & firstPend;
  assign eolMark   = eolReg & lastWord;
  assign wrAddr    = runAddr;
  assign wrData    = fifoData;
  assign wrBe      = beReg & tailMask;
endmodule

// File: rtl/fds_ctrl.sv
module fds_ctrl
  import fds_pkg::*;
#(
  parameter int FCW = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fieldStart,
  input  logic           restart,
  input  logic [3:0]     imemOp,
  input  logic [3:0]     hdrOp,
  input  logic [FCW-1:0] fifoBytes,
  input  logic           fifoHeadSync,
  input  logic           remZero,
  input  logic           lastWord,
  input  logic           codeMatch,
  output seqCtl_t        ctl,
  output logic           imemRd,
  output logic           fifoRd,
  output logic           wrReq,
  output logic           busy,
  output logic           errFlag,
  output logic           resyncFlag
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_HDR, S_OPF, S_OPD, S_EXEC, S_MOVE, S_WAIT, S_HALT
  } seqState_e;

  seqState_e state, nxt;
  logic [2:0] opLeft;
  logic       firstOp;
  logic       resync;
  logic       setResync, clrResync;
  logic       fifoHas;
  logic [2:0] newLen;

  assign fifoHas = (fifoBytes >= FCW'(4));
  assign newLen  = opWords(imemOp);

  always_comb begin
    ctl       = '0;
    nxt       = state;
    imemRd    = 1'b0;
    fifoRd    = 1'b0;
    wrReq     = 1'b0;
    setResync = 1'b0;
    clrResync = 1'b0;
    if (fieldStart && state != S_HALT) begin
      ctl.pcStart = 1'b1;
      nxt = S_FETCH;
    end else begin
      case (state)
        S_FETCH: begin
          imemRd = 1'b1;
          nxt = S_HDR;
        end
        S_HDR: begin
          ctl.hdrLd = 1'b1;
          ctl.pcInc = 1'b1;
          if (newLen == 3'd0) nxt = S_HALT;
          else if (newLen == 3'd1) nxt = S_EXEC;
          else nxt = S_OPF;
        end
        S_OPF: begin
          imemRd = 1'b1;
          nxt = S_OPD;
        end
        S_OPD: begin
          ctl.pcInc = 1'b1;
          ctl.opLd  = firstOp;
          nxt = (opLeft == 3'd1) ? S_EXEC : S_OPF;
        end
        S_EXEC: begin
          if (hdrOp == OP_BRANCH) begin
            ctl.pcJump = 1'b1;
            nxt = S_FETCH;
          end else if (hdrOp == OP_WAIT) begin
            nxt = S_WAIT;
          end else if (resync) begin
            nxt = S_FETCH;
          end else begin
            ctl.cntLd  = 1'b1;
            ctl.addrLd = hasAddr(hdrOp);
            nxt = S_MOVE;
          end
        end
        S_MOVE: begin
          if (remZero) begin
            nxt = S_FETCH;
          end else if (fifoHas) begin
            if (fifoHeadSync) begin
              setResync = 1'b1;
              nxt = S_FETCH;
            end else begin
              fifoRd = 1'b1;
              ctl.wordStep = 1'b1;
              if (isPut(hdrOp)) begin
                wrReq = 1'b1;
                ctl.addrStep = 1'b1;
              end
              if (lastWord) nxt = S_FETCH;
            end
          end
        end
        S_WAIT: begin
          if (fifoHas) begin
            fifoRd = 1'b1;
            if (fifoHeadSync && codeMatch) begin
              clrResync = 1'b1;
              nxt = S_FETCH;
            end
          end
        end
        S_HALT: begin
          if (restart) nxt = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opLeft  <= '0;
      firstOp <= 1'b0;
      resync  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_HDR) begin
        opLeft  <= newLen - 3'd1;
        firstOp <= 1'b1;
      end else if (state == S_OPD) begin
        opLeft  <= opLeft - 3'd1;
        firstOp <= 1'b0;
      end
      if (ctl.pcStart || clrResync) resync <= 1'b0;
      else if (setResync) resync <= 1'b1;
    end
  end

  assign busy       = (state != S_IDLE) && (state != S_HALT);
  assign errFlag    = (state == S_HALT);
  assign resyncFlag = resync;
endmodule

// File: rtl/fld_dma_seq.sv
module fld_dma_seq
  import fds_pkg::*;
#(
  parameter int IADDR_W    = 8,
  parameter int ADDR_W     = 32,
  parameter int FIFO_CNT_W = 10,
  parameter int CODE_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fieldStart,
  input  logic                  fieldOdd,
  input  logic                  restart,
  input  logic [IADDR_W-1:0]    oddStart,
  input  logic [IADDR_W-1:0]    evenStart,
  output logic                  imemRd,
  output logic [IADDR_W-1:0]    imemAddr,
  input  logic [31:0]           imemData,
  input  logic [FIFO_CNT_W-1:0] fifoBytes,
  input  logic [31:0]           fifoData,
  input  logic                  fifoHeadSync,
  input  logic [CODE_W-1:0]     fifoHeadCode,
  output logic                  fifoRd,
  output logic                  wrReq,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [31:0]           wrData,
  output logic [3:0]            wrBe,
  output logic                  wrSol,
  output logic                  wrEol,
  output logic                  busy,
  output logic                  errFlag,
  output logic                  resyncFlag,
  output logic [IADDR_W-1:0]    pcOut
);
  seqCtl_t           ctl;
  logic [3:0]        hdrOp;
  logic              remZero, lastWord, codeMatch, solMark, eolMark;
  logic [IADDR_W-1:0] pc;

  fds_ctrl #(.FCW(FIFO_CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .restart(restart),
    .imemOp(imemData[31:28]), .hdrOp(hdrOp), .fifoBytes(fifoBytes),
    .fifoHeadSync(fifoHeadSync), .remZero(remZero), .lastWord(lastWord),
    .codeMatch(codeMatch), .ctl(ctl), .imemRd(imemRd), .fifoRd(fifoRd),
    .wrReq(wrReq), .busy(busy), .errFlag(errFlag), .resyncFlag(resyncFlag)
  );

  fds_dpath #(.IAW(IADDR_W), .AW(ADDR_W), .CDW(CODE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fieldOdd(fieldOdd),
    .oddStart(oddStart), .evenStart(evenStart), .imemData(imemData),
    .fifoData(fifoData), .fifoHeadCode(fifoHeadCode), .pc(pc),
    .hdrOp(hdrOp), .remZero(remZero), .lastWord(lastWord),
    .codeMatch(codeMatch), .solMark(solMark), .eolMark(eolMark),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe)
  );

  assign imemAddr = pc;
  assign pcOut    = pc;
  assign wrSol    = wrReq & solMark;
  assign wrEol    = wrReq & eolMark;
endmodule

// File: rtl/fds_checker.sv
module fds_checker #(
  parameter int IAW = 8,
  parameter int FCW = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           fieldStart,
  input logic           fieldOdd,
  input logic           restart,
  input logic [IAW-1:0] oddStart,
  input logic [IAW-1:0] evenStart,
  input logic           imemRd,
  input logic [FCW-1:0] fifoBytes,
  input logic           fifoHeadSync,
  input logic           fifoRd,
  input logic           wrReq,
  input logic           wrSol,
  input logic           wrEol,
  input logic           busy,
  input logic           errFlag,
  input logic           resyncFlag,
  input logic [IAW-1:0] pcOut
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !errFlag) |-> (!wrReq && !fifoRd && !imemRd));

  p_start_pc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && !errFlag) |=> (pcOut == $past(fieldOdd ? oddStart : evenStart)));

  p_pop_needs_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> (fifoBytes >= FCW'(4)));

  p_wr_is_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> (fifoRd && !fifoHeadSync));

  p_line_marks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrSol || wrEol) |-> wrReq);

  p_no_wr_resync_r11: assert property (@(posedge clk) disable iff (!rstN)
    resyncFlag |-> !wrReq);

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!wrReq && !fifoRd && !imemRd && !busy));

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !restart) |=> errFlag);
endmodule

bind fld_dma_seq fds_checker #(.IAW(IADDR_W), .FCW(FIFO_CNT_W)) u_fds_chk (
  .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
  .restart(restart), .oddStart(oddStart), .evenStart(evenStart),
  .imemRd(imemRd), .fifoBytes(fifoBytes), .fifoHeadSync(fifoHeadSync),
  .fifoRd(fifoRd), .wrReq(wrReq), .wrSol(wrSol), .wrEol(wrEol),
  .busy(busy), .errFlag(errFlag), .resyncFlag(resyncFlag), .pcOut(pcOut)
);

// File: tb/test_fld_dma_seq.sv
module test_fld_dma_seq;
  localparam int IAW = 8;
  localparam int FCW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldStart = 1'b0, fieldOdd = 1'b0, restart = 1'b0;
  logic [IAW-1:0] oddStart = 8'h10, evenStart = 8'h40;
  logic imemRd;
  logic [IAW-1:0] imemAddr;
  logic [31:0] imemData = '0;
  logic [FCW-1:0] fifoBytes;
  logic [31:0] fifoData;
  logic fifoHeadSync;
  logic [3:0] fifoHeadCode;
  logic fifoRd, wrReq, wrSol, wrEol, busy, errFlag, resyncFlag;
  logic [31:0] wrAddr, wrData;
  logic [3:0] wrBe;
  logic [IAW-1:0] pcOut;

  always #2 clk = ~clk;

  fld_dma_seq i_fld_dma_seq (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .restart(restart), .oddStart(oddStart), .evenStart(evenStart),
    .imemRd(imemRd), .imemAddr(imemAddr), .imemData(imemData),
    .fifoBytes(fifoBytes), .fifoData(fifoData), .fifoHeadSync(fifoHeadSync),
    .fifoHeadCode(fifoHeadCode), .fifoRd(fifoRd), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .wrSol(wrSol),
    .wrEol(wrEol), .busy(busy), .errFlag(errFlag), .resyncFlag(resyncFlag),
    .pcOut(pcOut)
  );

  // program memory model, one-cycle read latency
  logic [31:0] mem [256];
  always @(posedge clk) if (imemRd) imemData <= mem[imemAddr];

  // FIFO model
  logic [31:0] fD [64];
  logic        fS [64];
  logic [3:0]  fC [64];
  logic [15:0] head = '0, tail = '0;
  assign fifoBytes    = FCW'((tail - head) << 2);
  assign fifoData     = fD[head[5:0]];
  assign fifoHeadSync = fS[head[5:0]];
  assign fifoHeadCode = fC[head[5:0]];
  always @(posedge clk) if (fifoRd) head <= head + 16'd1;

  // write log
  logic [31:0] lA [64];
  logic [31:0] lD [64];
  logic [3:0]  lB [64];
  logic        lS [64];
  logic        lE [64];
  int nW = 0;
  always @(posedge clk) if (rstN && wrReq) begin
    lA[nW] <= wrAddr; lD[nW] <= wrData; lB[nW] <= wrBe;
    lS[nW] <= wrSol;  lE[nW] <= wrEol;  nW <= nW + 1;
  end

  int nChk = 0, nFail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nChk = nChk + 1; nFail = nFail + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [3:0] op, input logic sol, input logic eol,
                                      input logic [3:0] be, input logic [11:0] cnt);
    hdr = {op, sol, eol, 10'b0, be, cnt};
  endfunction

  task automatic push(input logic [31:0] d);
    fD[tail[5:0]] = d; fS[tail[5:0]] = 1'b0; fC[tail[5:0]] = 4'h0; tail = tail + 16'd1;
  endtask

  task automatic pushMark(input logic [3:0] c);
    fD[tail[5:0]] = 32'h0; fS[tail[5:0]] = 1'b1; fC[tail[5:0]] = c; tail = tail + 16'd1;
  endtask

  task automatic pulseStart(input logic odd);
    @(negedge clk); fieldStart = 1'b1; fieldOdd = odd;
    @(negedge clk); fieldStart = 1'b0;
  endtask

  task automatic startField(input logic odd);
    pulseStart(odd);
    chk("R2 start pc", 32'(pcOut), 32'(odd ? oddStart : evenStart));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(errFlag), 0);
    chk("R1 resync", 32'(resyncFlag), 0);
    chk("R1 pc", 32'(pcOut), 0);
    chk("R1 strobes", {29'b0, wrReq, fifoRd, imemRd}, 0);
  endtask

  task automatic t_packed;
    int b;
    mem[8'h40] = hdr(4'b0001, 1'b1, 1'b1, 4'hF, 12'd10);
    mem[8'h41] = 32'h1000;
    mem[8'h42] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h43] = 32'hF;
    b = nW;
    startField(1'b0);
    push(32'hA0A0_0000); push(32'hA1A1_1111); push(32'hA2A2_2222);
    idle(40);
    chk("R4 count", 32'(nW - b), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 addr", lA[b+i], 32'h1000 + 32'(4*i));
    end
    chk("R4 data0", lD[b], 32'hA0A0_0000);
    chk("R4 data2", lD[b+2], 32'hA2A2_2222);
    chk("R4 be0", 32'(lB[b]), 32'hF);
    chk("R4 be last", 32'(lB[b+2]), 32'h3);
    chk("R10 sol", {29'b0, lS[b], lS[b+1], lS[b+2]}, 32'b100);
    chk("R10 eol", {29'b0, lE[b], lE[b+1], lE[b+2]}, 32'b001);
    chk("R9 fifo drained", 32'(fifoBytes), 0);
    chk("R3 pc after", 32'(pcOut), 32'h44);
  endtask

  task automatic t_continue;
    int b;
    mem[8'h40] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd8);
    mem[8'h41] = 32'h2000;
    mem[8'h42] = hdr(4'b0101, 1'b0, 1'b0, 4'h5, 12'd4);
    mem[8'h43] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h44] = 32'hF;
    b = nW;
    startField(1'b0);
    push(32'hB0); push(32'hB1); push(32'hB2);
    idle(40);
    chk("R5 count", 32'(nW - b), 3);
    chk("R5 addr", lA[b+2], 32'h2008);
    chk("R5 data", lD[b+2], 32'hB2);
    chk("R5 be", 32'(lB[b+2]), 32'h5);
    chk("R10 no marks", {30'b0, lS[b+2], lE[b+2]}, 0);
  endtask

  task automatic t_skip;
    int b;
    mem[8'h40] = hdr(4'b0010, 1'b0, 1'b0, 4'h0, 12'd8);
    mem[8'h41] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd4);
    mem[8'h42] = 32'h3000;
    mem[8'h43] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h44] = 32'hF;
    b = nW;
    startField(1'b0);
    push(32'hD0); push(32'hD1); push(32'hD2);
    idle(40);
    chk("R6 count", 32'(nW - b), 1);
    chk("R6 data", lD[b], 32'hD2);
    chk("R6 addr", lA[b], 32'h3000);
    chk("R6 drained", 32'(fifoBytes), 0);
  endtask

  task automatic t_lengths;
    int b;
    mem[8'h10] = hdr(4'b1001, 1'b0, 1'b0, 4'hF, 12'd0);
    for (int i = 1; i < 5; i++) mem[8'h10 + i] = 32'h0;
    mem[8'h15] = hdr(4'b1011, 1'b0, 1'b0, 4'hF, 12'd0);
    mem[8'h16] = 32'h0; mem[8'h17] = 32'h0;
    mem[8'h18] = hdr(4'b0101, 1'b0, 1'b0, 4'hF, 12'd0);
    mem[8'h19] = hdr(4'b0010, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h1A] = hdr(4'b1010, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h1B] = 32'h0;
    mem[8'h1C] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h1D] = 32'hF;
    b = nW;
    startField(1'b1);
    idle(80);
    chk("R3 pc total", 32'(pcOut), 32'h1E);
    chk("R3 no writes", 32'(nW - b), 0);
    chk("R3 no error", 32'(errFlag), 0);
  endtask

  task automatic t_jump;
    int b;
    mem[8'h40] = hdr(4'b0111, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h41] = 32'h60;
    mem[8'h42] = 32'h0;
    mem[8'h60] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd4);
    mem[8'h61] = 32'h4000;
    mem[8'h62] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h63] = 32'hF;
    b = nW;
    startField(1'b0);
    push(32'hC0DE);
    idle(40);
    chk("R7 err", 32'(errFlag), 0);
    chk("R7 pc", 32'(pcOut), 32'h64);
    chk("R7 write", lA[b], 32'h4000);
    chk("R7 data", lD[b], 32'hC0DE);
  endtask

  task automatic t_sync;
    int b;
    mem[8'h40] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h41] = 32'h3;
    mem[8'h42] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd4);
    mem[8'h43] = 32'h5000;
    mem[8'h44] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h45] = 32'hF;
    b = nW;
    startField(1'b0);
    idle(20);
    chk("R8 stalled busy", 32'(busy), 1);
    chk("R8 stalled pc", 32'(pcOut), 32'h42);
    chk("R8 stalled no write", 32'(nW - b), 0);
    push(32'hBAD0); pushMark(4'h5); pushMark(4'h3); push(32'h600D);
    idle(40);
    chk("R8 count", 32'(nW - b), 1);
    chk("R8 data", lD[b], 32'h600D);
    chk("R8 addr", lA[b], 32'h5000);
    chk("R8 drained", 32'(fifoBytes), 0);
    chk("R8 pc", 32'(pcOut), 32'h46);
  endtask

  task automatic t_resync;
    int b;
    mem[8'h40] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd12);
    mem[8'h41] = 32'h6000;
    mem[8'h42] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd4);
    mem[8'h43] = 32'h7000;
    mem[8'h44] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h45] = 32'h2;
    mem[8'h46] = hdr(4'b0001, 1'b0, 1'b0, 4'hF, 12'd4);
    mem[8'h47] = 32'h8000;
    mem[8'h48] = hdr(4'b1000, 1'b0, 1'b0, 4'h0, 12'd0);
    mem[8'h49] = 32'hF;
    b = nW;
    startField(1'b0);
    push(32'hE0); pushMark(4'h1);
    idle(40);
    chk("R11 one write", 32'(nW - b), 1);
    chk("R11 first addr", lA[b], 32'h6000);
    chk("R11 flag set", 32'(resyncFlag), 1);
    chk("R11 pc at wait", 32'(pcOut), 32'h46);
    chk("R11 fifo empty", 32'(fifoBytes), 0);
    pushMark(4'h2); push(32'hE1);
    idle(40);
    chk("R11 realigned count", 32'(nW - b), 2);
    chk("R11 realigned addr", lA[b+1], 32'h8000);
    chk("R11 realigned data", lD[b+1], 32'hE1);
    chk("R11 flag clear", 32'(resyncFlag), 0);
  endtask

  task automatic t_halt;
    logic [IAW-1:0] pcHeld;
    mem[8'h40] = 32'h0;
    startField(1'b0);
    idle(10);
    chk("R12 err", 32'(errFlag), 1);
    chk("R12 not busy", 32'(busy), 0);
    pcHeld = pcOut;
    chk("R12 pc past header", 32'(pcHeld), 32'h41);
    pulseStart(1'b1);
    idle(5);
    chk("R12 start ignored err", 32'(errFlag), 1);
    chk("R12 start ignored pc", 32'(pcOut), 32'(pcHeld));
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    idle(2);
    chk("R12 restart err", 32'(errFlag), 0);
    chk("R12 restart idle", 32'(busy), 0);
  endtask

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rstN = 1'b1;
    idle(2);
    t_reset;
    t_packed;
    t_continue;
    t_skip;
    t_lengths;
    t_jump;
    t_sync;
    t_resync;
    t_halt;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule